// File: doc/BRIEF.md
# Wear-Spread Split Counter

This block keeps a 16-bit up-counter whose value persists in a byte-wide, endurance-limited memory. The upper byte lives at one fixed address and is rewritten only when the lower byte carries, once every 256 counts. The lower byte, which changes on every count, is not kept at one address. It goes to one of 2^SEL_BITS slot addresses, and the slot is picked by the low SEL_BITS bits of the current upper byte. Every carry therefore moves the lower-byte traffic to the next slot, and each lower-byte location wears out 2^SEL_BITS times more slowly.

At power-up the host pulses a load request. The controller fetches the upper byte, works out the slot from it, fetches the lower byte from that slot and presents the binary count. After that, each increment request bumps the count and writes back only the bytes that changed. On a carry, the lower byte is written before the upper byte. The memory port is a plain synchronous single-port interface whose read data arrives one cycle after the read is issued.

Top module: `wear_counter`

## Requirements
- R1: During and after reset, `count` is 0x0000, `busy` is low and `memEn` is low.
- R2: An increment accepted while idle makes `count` become (old + 1) mod 65536 on the next clock edge. While idle with no request, `count` holds its value.
- R3: An increment that does not carry makes exactly one memory write, with `busy` high for one cycle. The write goes to address SLOT_BASE + (new high byte mod 2^SEL_BITS) and its data is the new low byte.
- R4: An increment that carries (low byte becomes 0x00) makes exactly two writes on consecutive cycles, with `busy` high for two cycles. The first write stores 0x00 to the slot selected by the new high byte. The second stores the new high byte to HI_ADDR.
- R5: Incrementing 0xFFFF gives 0x0000. Its low-byte write goes to slot 0, at address SLOT_BASE, and the high byte stored is 0x00.
- R6: A load issues a read of HI_ADDR and then a read of the slot selected by the returned high byte. `busy` is high for four cycles, after which `count` = {high, low}. Read data is taken one cycle after each read is issued.
- R7: When load and increment are both requested while idle, the load is taken and the increment is dropped.
- R8: Requests raised while `busy` is high are ignored. They change neither the count nor the memory traffic.
- R9: The memory port is enabled only while `busy` is high.
- R10: After any run of increments, a fresh load reads back the same count from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| incReq | input | 1 | Increment request, taken when idle |
| loadReq | input | 1 | Restore-from-memory request, taken when idle |
| count | output | 16 | Current binary count |
| busy | output | 1 | Operation in progress |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Write when high, read when low (with memEn) |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid one cycle after a read |

## Verification
A corrupted high-byte register shows at once. The next low-byte write, or the second read of a load, goes to the wrong slot address in the same cycle the access is issued. A bad carry flag shows on the cycle after the write of 0x00: the high-byte write is either missing or spurious there, so the write count of that increment changes. A corrupted low byte shows on `count` immediately and in the write data of the next increment. Reloading after a long sweep exposes any slot that was written with the wrong data.

// File: rtl/wc_pkg.sv
package wc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HI,
    ST_CAP_HI,
    ST_RD_LO,
    ST_CAP_LO,
    ST_WR_LO,
    ST_WR_HI
  } wc_state_e;

  typedef struct packed {
    logic bump;
    logic rdHi;
    logic capHi;
    logic rdLo;
    logic capLo;
    logic wrLo;
    logic wrHi;
  } wc_strobe_t;

endpackage

// File: rtl/wc_ctrl.sv
module wc_ctrl
  import wc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       incReq,
  input  logic       loadReq,
  input  logic       carry,
  output wc_strobe_t stb,
  output logic       busy
);

  wc_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (loadReq) begin
          nextState = ST_RD_HI;
        end else if (incReq) begin
          stb.bump  = 1'b1;
          nextState = ST_WR_LO;
        end
      end
      ST_RD_HI: begin
        stb.rdHi  = 1'b1;
        nextState = ST_CAP_HI;
      end
      ST_CAP_HI: begin
        stb.capHi = 1'b1;
        nextState = ST_RD_LO;
      end
      ST_RD_LO: begin
        stb.rdLo  = 1'b1;
        nextState = ST_CAP_LO;
      end
      ST_CAP_LO: begin
        stb.capLo = 1'b1;
        nextState = ST_IDLE;
      end
      ST_WR_LO: begin
        stb.wrLo  = 1'b1;
        nextState = carry ? ST_WR_HI : ST_IDLE;
      end
      ST_WR_HI: begin
        stb.wrHi  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/wc_datapath.sv
module wc_datapath
  import wc_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                SEL_BITS  = 4,
  parameter logic [ADDR_W-1:0] HI_ADDR   = '0,
  parameter logic [ADDR_W-1:0] SLOT_BASE = ADDR_W'(16)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wc_strobe_t        stb,
  input  logic [7:0]        memRdata,
  output logic [15:0]       count,
  output logic              carry,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata
);

  localparam int NUM_SLOTS = 1 << SEL_BITS;
  localparam logic [7:0] LO_MAX = 8'hFF;

  logic [7:0]        hiReg, loReg;
  logic              carryReg;
  logic [ADDR_W-1:0] slotAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg    <= '0;
      loReg    <= '0;
      carryReg <= 1'b0;
    end else begin
      if (stb.bump) begin
        {hiReg, loReg} <= {hiReg, loReg} + 16'd1;
        carryReg       <= (loReg == LO_MAX);
      end
      if (stb.capHi) hiReg <= memRdata;
      if (stb.capLo) loReg <= memRdata;
    end
  end

  // slot index is the low SEL_BITS of the stored high byte
  generate
    if (NUM_SLOTS >= 256) begin : g_fullSel
      assign slotAddr = SLOT_BASE + ADDR_W'(hiReg);
    end else begin : g_partSel
      assign slotAddr = SLOT_BASE + ADDR_W'(hiReg[SEL_BITS-1:0]);
    end
  endgenerate

  assign memEn    = stb.rdHi | stb.rdLo | stb.wrLo | stb.wrHi;
  assign memWe    = stb.wrLo | stb.wrHi;
  assign memAddr  = (stb.rdHi | stb.wrHi) ? HI_ADDR : slotAddr;
  assign memWdata = stb.wrHi ? hiReg : loReg;
  assign count    = {hiReg, loReg};
  assign carry    = carryReg;

endmodule

// File: rtl/wear_counter.sv
module wear_counter
  import wc_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                SEL_BITS  = 4,
  parameter logic [ADDR_W-1:0] HI_ADDR   = '0,
  parameter logic [ADDR_W-1:0] SLOT_BASE = ADDR_W'(16)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              incReq,
  input  logic              loadReq,
  output logic [15:0]       count,
  output logic              busy,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata
);

  wc_strobe_t stb;
  logic       carry;

  wc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .incReq  (incReq),
    .loadReq (loadReq),
    .carry   (carry),
    .stb     (stb),
    .busy    (busy)
  );

  wc_datapath #(
    .ADDR_W    (ADDR_W),
    .SEL_BITS  (SEL_BITS),
    .HI_ADDR   (HI_ADDR),
    .SLOT_BASE (SLOT_BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .memRdata (memRdata),
    .count    (count),
    .carry    (carry),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/wear_counter_chk.sv
module wear_counter_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                SEL_BITS  = 4,
  parameter logic [ADDR_W-1:0] HI_ADDR   = '0,
  parameter logic [ADDR_W-1:0] SLOT_BASE = ADDR_W'(16)
) (
  input logic              clk,
  input logic              rstN,
  input logic              incReq,
  input logic              loadReq,
  input logic [15:0]       count,
  input logic              busy,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWdata
);

  localparam logic [7:0] SEL_MASK = 8'((1 << SEL_BITS) - 1);

  logic [ADDR_W-1:0] expSlot;
  logic              loWrite, hiWrite;
  assign expSlot = SLOT_BASE + ADDR_W'(count[15:8] & SEL_MASK);
  assign loWrite = memEn && memWe && (memAddr != HI_ADDR);
  assign hiWrite = memEn && memWe && (memAddr == HI_ADDR);

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (count == 16'h0000 && !busy && !memEn)); // R1

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && incReq && !loadReq) |=> (count == $past(count) + 16'd1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !incReq && !loadReq) |=> $stable(count)); // R2

  AST_SLOT_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memAddr != HI_ADDR) |-> (memAddr == expSlot)); // R3

  AST_LO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    loWrite |-> (memWdata == count[7:0])); // R3

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rstN)
    hiWrite |-> ($past(loWrite) && count[7:0] == 8'h00 && memWdata == count[15:8])); // R4

  AST_CARRY_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (loWrite && memWdata == 8'h00) |=> hiWrite); // R4

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadReq) |=> (memEn && !memWe && memAddr == HI_ADDR)); // R7

  AST_PORT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memEn); // R9

endmodule

bind wear_counter wear_counter_chk #(
  .ADDR_W    (ADDR_W),
  .SEL_BITS  (SEL_BITS),
  .HI_ADDR   (HI_ADDR),
  .SLOT_BASE (SLOT_BASE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .incReq   (incReq),
  .loadReq  (loadReq),
  .count    (count),
  .busy     (busy),
  .memEn    (memEn),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata)
);

// File: tb/wear_counter_test.sv
module wear_counter_test;

  localparam int         AW   = 8;
  localparam int         SEL  = 3;
  localparam logic [7:0] HIA  = 8'h02;
  localparam logic [7:0] SB   = 8'h20;
  localparam int         NSTEP = 2304;

  logic clk = 1'b0, rstN = 1'b0, incReq = 1'b0, loadReq = 1'b0;
  logic [15:0]   count;
  logic          busy, memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWdata, memRdata;

  logic [7:0] mem [256];
  int wrN = 0, rdN = 0;
  int wrA [4], wrD [4], rdA [4];
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int expCnt;

  always #4 clk = ~clk;  // 125 MHz

  wear_counter #(.ADDR_W(AW), .SEL_BITS(SEL), .HI_ADDR(HIA), .SLOT_BASE(SB)) uut (
    .clk(clk), .rstN(rstN), .incReq(incReq), .loadReq(loadReq),
    .count(count), .busy(busy), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // synchronous byte memory with access log
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        if (wrN < 4) begin wrA[wrN] = int'(memAddr); wrD[wrN] = int'(memWdata); end
        wrN++;
      end else begin
        memRdata <= mem[memAddr];
        if (rdN < 4) rdA[rdN] = int'(memAddr);
        rdN++;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int slotOf(int hi);
    return int'(SB) + (hi % (1 << SEL));
  endfunction

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic doInc();
    int cyc, nxt, hi, lo;
    wrN = 0; rdN = 0;
    incReq = 1'b1;
    @(negedge clk);
    incReq = 1'b0;
    waitIdle(cyc);
    nxt = (expCnt + 1) & 16'hFFFF;
    hi = nxt >> 8; lo = nxt & 8'hFF;
    check("R2", "count after increment", int'(count), nxt);
    check("R3", "low write slot", wrA[0], slotOf(hi));
    check("R3", "low write data", wrD[0], lo);
    check("R10", "slot content", int'(mem[slotOf(hi)]), lo);
    if (lo != 0) begin
      check("R3", "writes without carry", wrN, 1);
      check("R3", "busy cycles without carry", cyc, 1);
    end else begin
      check("R4", "writes with carry", wrN, 2);
      check("R4", "busy cycles with carry", cyc, 2);
      check("R4", "second write addr", wrA[1], int'(HIA));
      check("R4", "second write data", wrD[1], hi);
    end
    check("R6", "no reads during increment", rdN, 0);
    expCnt = nxt;
  endtask

  task automatic doLoad(bit preset, int hi, int lo);
    int cyc;
    if (preset) begin
      mem[HIA] = 8'(hi);
      mem[slotOf(hi)] = 8'(lo);
    end
    wrN = 0; rdN = 0;
    loadReq = 1'b1;
    @(negedge clk);
    loadReq = 1'b0;
    waitIdle(cyc);
    check("R6", "count after load", int'(count), (hi << 8) | lo);
    check("R6", "load busy cycles", cyc, 4);
    check("R6", "load read count", rdN, 2);
    check("R6", "first read addr", rdA[0], int'(HIA));
    check("R6", "second read addr", rdA[1], slotOf(hi));
    check("R6", "no writes during load", wrN, 0);
    expCnt = (hi << 8) | lo;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", "count in reset", int'(count), 0);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "memEn in reset", int'(memEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "count after reset", int'(count), 0);
    expCnt = 0;

    // idle hold with no request
    wrN = 0;
    repeat (5) @(negedge clk);
    check("R2", "idle count hold", int'(count), 0);
    check("R9", "no accesses while idle", wrN + rdN, 0);

    // restore and sweep through several carries
    doLoad(1'b1, 8'h03, 8'hF0);
    for (int s = 0; s < NSTEP; s++) doInc();
    doLoad(1'b0, expCnt >> 8, expCnt & 8'hFF);
    check("R10", "reload after sweep", int'(count), (16'h03F0 + NSTEP) & 16'hFFFF);

    // wrap at the top
    doLoad(1'b1, 8'hFF, 8'hFE);
    doInc();
    doInc();
    check("R5", "wrapped count", int'(count), 0);
    check("R5", "wrap slot is slot 0", wrA[0], int'(SB));
    check("R5", "stored high byte after wrap", int'(mem[HIA]), 0);
    doLoad(1'b0, 0, 0);

    // load wins over increment
    mem[HIA] = 8'h12; mem[slotOf(8'h12)] = 8'h34;
    wrN = 0; rdN = 0;
    loadReq = 1'b1; incReq = 1'b1;
    @(negedge clk);
    loadReq = 1'b0; incReq = 1'b0;
    begin int c; waitIdle(c); end
    check("R7", "priority count", int'(count), 16'h1234);
    check("R7", "priority no writes", wrN, 0);
    expCnt = 16'h1234;

    // requests while busy are ignored
    mem[HIA] = 8'h77; mem[slotOf(8'h77)] = 8'h66;
    wrN = 0; rdN = 0;
    incReq = 1'b1;
    @(negedge clk);
    incReq = 1'b1; loadReq = 1'b1;
    @(negedge clk);
    incReq = 1'b0; loadReq = 1'b0;
    begin int c; waitIdle(c); end
    check("R8", "count after busy requests", int'(count), 16'h1235);
    check("R8", "writes after busy requests", wrN, 1);
    check("R8", "reads after busy requests", rdN, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule